// File: doc/BRIEF.md
# Sticky Interrupt Aggregator with Register Access

This block gathers a set of peripheral interrupt lines (24 by default) and presents them to one CPU as a single combined interrupt request. Each line is brought into the clock domain through a multi-flop synchronizer and then detected either as a level or as a rising and/or falling edge, as chosen per source by two trigger registers. A detected event sets a per-source pending flag that stays set until software clears it by writing a one to it.

Pending flags are gated by an enable mask. Software can load the mask whole, or change single bits through a set alias and a clear alias without a read-modify-write. The pending-and-enabled set can be read from an identity register, and the registered OR of that set drives the interrupt output. Software reaches all registers through a simple 32-bit bus with a one-cycle write strobe and a read strobe whose data appears one cycle later.

Top module: `irq_sticky_agg`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: A write to the pending register (byte address 0x10) clears each pending bit whose write-data bit is 1 and leaves bits written with 0 unchanged; writing all ones clears every pending bit whose source is not setting it again.
- R3: A write to the set alias (0x20) sets the enable bits whose data bits are 1, and a write to the clear alias (0x1C) clears them; zero data bits leave enables unchanged. Both aliases read back the enable mask.
- R4: A write to the enable register (0x18) loads the mask directly, so writing zero masks every source at once.
- R5: The identity register (0x38) reads the bitwise AND of the pending and enable masks.
- R6: A source with bit 0 in both trigger registers is level-detected: its pending bit is set on every cycle the synchronized input is high, so it sets again right after being cleared while the input stays high.
- R7: A source with its bit set only in the rising trigger register (0x5C) sets its pending bit only on a low-to-high change of the input; holding the input high does not set it again after a clear.
- R8: A source with its bit set only in the falling trigger register (0x60) sets its pending bit only on a high-to-low change of the input.
- R9: A source with its bit set in both trigger registers sets its pending bit on either edge.
- R10: When a detected event and a write-one clear hit the same pending bit in the same cycle, the bit ends set.
- R11: `irq_o` equals the OR of the identity bits one clock cycle earlier.
- R12: Register bits at and above bit 24 read as zero and ignore writes; data for a source sits in the bit whose index is that source's number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | One-cycle write strobe |
| rd_en_i | input | 1 | Read strobe; data valid the next cycle |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| src_i | input | 24 | Asynchronous interrupt source lines |
| irq_o | output | 1 | Combined interrupt request to the CPU |

## Verification
Sticky latching is tried with static level patterns held high while a clear-all is written, which separates level detection (bits reappear at once) from a clear that wins over a set. Single-source rising, falling and dual-edge runs hold the input still after the edge and clear, showing whether edge mode ever falls back to level behaviour. Random sequences of direct, set-alias and clear-alias mask writes mixed with random source patterns compare enable and identity reads against a bench model, and a mask written just before the output is sampled tells the one-cycle output register apart from a combinational path.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   // Byte offsets of the register window (software map)
   localparam logic [7:0] OFS_PEND    = 8'h10;
   localparam logic [7:0] OFS_MASK    = 8'h18;
   localparam logic [7:0] OFS_MASKCLR = 8'h1C;
   localparam logic [7:0] OFS_MASKSET = 8'h20;
   localparam logic [7:0] OFS_IDENT   = 8'h38;
   localparam logic [7:0] OFS_TRIG_R  = 8'h5C;
   localparam logic [7:0] OFS_TRIG_F  = 8'h60;

   // Decoded write strobes, one per writable register path
   typedef struct packed {
      logic pend_w1c;
      logic mask_ld;
      logic mask_set;
      logic mask_clr;
      logic trig_r_ld;
      logic trig_f_ld;
   } agg_wstrb_t;

endpackage

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic src_i,
   input  logic rise_en_i,
   input  logic fall_en_i,
   output logic set_o
);

   localparam int unsigned MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_src_detect: SYNC_STAGES must be at least 2");
   end

   logic [MSB:0] sync_q;
   logic         prev_q;
   logic         now;
   logic         edge_mode;
   logic         rise_hit;
   logic         fall_hit;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[MSB-1:0], src_i};
         prev_q <= sync_q[MSB];
      end
   end

   assign now       = sync_q[MSB];
   assign edge_mode = rise_en_i | fall_en_i;
   assign rise_hit  = rise_en_i & now & ~prev_q;
   assign fall_hit  = fall_en_i & ~now & prev_q;
   assign set_o     = edge_mode ? (rise_hit | fall_hit) : now;

   // R7
   rise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_en_i && !fall_en_i && set_o) |-> (now && !$past(now)));

   // R8
   fall_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fall_en_i && !rise_en_i && set_o) |-> (!now && $past(now)));

endmodule

// File: rtl/irq_state_bank.sv
module irq_state_bank
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_SRC = 24
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  agg_wstrb_t         wstrb_i,
   input  logic [NUM_SRC-1:0] wdata_i,
   input  logic [NUM_SRC-1:0] set_i,
   output logic [NUM_SRC-1:0] pend_o,
   output logic [NUM_SRC-1:0] mask_o,
   output logic [NUM_SRC-1:0] trig_r_o,
   output logic [NUM_SRC-1:0] trig_f_o
);

   logic [NUM_SRC-1:0] pend_q, pend_d;
   logic [NUM_SRC-1:0] mask_q, mask_d;
   logic [NUM_SRC-1:0] trig_r_q, trig_f_q;
   logic [NUM_SRC-1:0] clr_bits;

   assign clr_bits = wstrb_i.pend_w1c ? wdata_i : '0;

   // Hardware set takes priority over software clear
   always_comb begin
      pend_d = (pend_q & ~clr_bits) | set_i;
   end

   always_comb begin
      mask_d = mask_q;
      if (wstrb_i.mask_ld)  mask_d = wdata_i;
      if (wstrb_i.mask_set) mask_d = mask_q | wdata_i;
      if (wstrb_i.mask_clr) mask_d = mask_q & ~wdata_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q   <= '0;
         mask_q   <= '0;
         trig_r_q <= '0;
         trig_f_q <= '0;
      end else begin
         pend_q <= pend_d;
         mask_q <= mask_d;
         if (wstrb_i.trig_r_ld) trig_r_q <= wdata_i;
         if (wstrb_i.trig_f_ld) trig_f_q <= wdata_i;
      end
   end

   assign pend_o   = pend_q;
   assign mask_o   = mask_q;
   assign trig_r_o = trig_r_q;
   assign trig_f_o = trig_f_q;

   // R2
   w1c_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wstrb_i.pend_w1c && ((wdata_i & ~set_i) != '0))
      |=> ((pend_o & $past(wdata_i & ~set_i)) == '0));

   // R10
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((pend_o & $past(set_i)) == $past(set_i)));

   // R3
   mask_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wstrb_i.mask_set |=> ((mask_o & $past(wdata_i)) == $past(wdata_i)));

   // R3
   mask_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wstrb_i.mask_clr |=> ((mask_o & $past(wdata_i)) == '0));

   // R4
   mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wstrb_i.mask_ld && wdata_i == '0) |=> (mask_o == '0));

endmodule

// File: rtl/irq_regbus.sv
module irq_regbus
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_SRC = 24,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 8
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic [NUM_SRC-1:0] trig_r_i,
   input  logic [NUM_SRC-1:0] trig_f_i,
   output agg_wstrb_t         wstrb_o,
   output logic [DATA_W-1:0]  rd_data_o
);

   localparam logic [ADDR_W-1:0] A_PEND    = ADDR_W'(OFS_PEND);
   localparam logic [ADDR_W-1:0] A_MASK    = ADDR_W'(OFS_MASK);
   localparam logic [ADDR_W-1:0] A_MASKCLR = ADDR_W'(OFS_MASKCLR);
   localparam logic [ADDR_W-1:0] A_MASKSET = ADDR_W'(OFS_MASKSET);
   localparam logic [ADDR_W-1:0] A_IDENT   = ADDR_W'(OFS_IDENT);
   localparam logic [ADDR_W-1:0] A_TRIG_R  = ADDR_W'(OFS_TRIG_R);
   localparam logic [ADDR_W-1:0] A_TRIG_F  = ADDR_W'(OFS_TRIG_F);

   logic [NUM_SRC-1:0] rd_sel;
   logic [DATA_W-1:0]  rd_q;

   always_comb begin
      wstrb_o           = '0;
      wstrb_o.pend_w1c  = wr_en_i && (addr_i == A_PEND);
      wstrb_o.mask_ld   = wr_en_i && (addr_i == A_MASK);
      wstrb_o.mask_clr  = wr_en_i && (addr_i == A_MASKCLR);
      wstrb_o.mask_set  = wr_en_i && (addr_i == A_MASKSET);
      wstrb_o.trig_r_ld = wr_en_i && (addr_i == A_TRIG_R);
      wstrb_o.trig_f_ld = wr_en_i && (addr_i == A_TRIG_F);
   end

   always_comb begin
      case (addr_i)
         A_PEND:    rd_sel = pend_i;
         A_MASK,
         A_MASKCLR,
         A_MASKSET: rd_sel = mask_i;
         A_IDENT:   rd_sel = pend_i & mask_i;
         A_TRIG_R:  rd_sel = trig_r_i;
         A_TRIG_F:  rd_sel = trig_f_i;
         default:   rd_sel = '0;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_q <= '0;
      end else if (rd_en_i) begin
         rd_q <= DATA_W'(rd_sel);
      end
   end

   assign rd_data_o = rd_q;

   // R12
   upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_en_i |=> ((rd_data_o >> NUM_SRC) == '0));

endmodule

// File: rtl/irq_sticky_agg.sv
module irq_sticky_agg
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_SRC     = 24,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               wr_en_i,
   input  logic               rd_en_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rd_data_o,
   input  logic [NUM_SRC-1:0] src_i,
   output logic               irq_o
);

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_nsrc
      $error("irq_sticky_agg: NUM_SRC must lie in 1..DATA_W");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("irq_sticky_agg: ADDR_W too narrow for the register window");
   end

   agg_wstrb_t         wstrb;
   logic [NUM_SRC-1:0] set_vec;
   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] trig_r;
   logic [NUM_SRC-1:0] trig_f;
   logic [NUM_SRC-1:0] ident;
   logic               irq_q;

   if (NUM_SRC < DATA_W) begin : g_hi_bits
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata_i[DATA_W-1:NUM_SRC];
   end

   for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
      irq_src_detect #(
         .SYNC_STAGES(SYNC_STAGES)
      ) i_det (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .src_i     (src_i[gi]),
         .rise_en_i (trig_r[gi]),
         .fall_en_i (trig_f[gi]),
         .set_o     (set_vec[gi])
      );
   end

   irq_state_bank #(
      .NUM_SRC(NUM_SRC)
   ) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wstrb_i  (wstrb),
      .wdata_i  (wdata_i[NUM_SRC-1:0]),
      .set_i    (set_vec),
      .pend_o   (pend),
      .mask_o   (mask),
      .trig_r_o (trig_r),
      .trig_f_o (trig_f)
   );

   irq_regbus #(
      .NUM_SRC(NUM_SRC),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) i_bus (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .rd_en_i   (rd_en_i),
      .addr_i    (addr_i),
      .pend_i    (pend),
      .mask_i    (mask),
      .trig_r_i  (trig_r),
      .trig_f_i  (trig_f),
      .wstrb_o   (wstrb),
      .rd_data_o (rd_data_o)
   );

   assign ident = pend & mask;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |ident;
   end

   assign irq_o = irq_q;

   // R11
   irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_o == $past(|(pend & mask))));

   // R5
   ident_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask == '0) |=> (irq_o == 1'b0));

endmodule

// File: tb/test_irq_sticky_agg.sv
`timescale 1ns/1ps
module test_irq_sticky_agg;

   localparam int NS = 24;
   localparam logic [31:0] LOW = 32'h00FF_FFFF;

   localparam logic [7:0] A_PEND = 8'h10, A_MASK = 8'h18, A_MCLR = 8'h1C,
                          A_MSET = 8'h20, A_IDENT = 8'h38, A_TR = 8'h5C, A_TF = 8'h60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rd_data;
   logic [NS-1:0] src = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] mdl_mask = '0;

   always #10 clk = ~clk;

   irq_sticky_agg i_irq_sticky_agg (
      .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
      .addr_i(addr), .wdata_i(wdata), .rd_data_o(rd_data),
      .src_i(src), .irq_o(irq)
   );

   function automatic logic [31:0] apply_mask_op(input int op, input logic [31:0] cur,
                                                 input logic [31:0] d);
      case (op)
         0:       return d & LOW;
         1:       return (cur | d) & LOW;
         default: return cur & ~d & LOW;
      endcase
   endfunction

   function automatic logic [31:0] exp_ident(input logic [31:0] p, input logic [31:0] m);
      return p & m & LOW;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a negedge; the write takes effect at the following posedge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // Called at a negedge; data is sampled one cycle later
   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] d;
      void'($urandom(32'd7341));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      chk("R1 irq", {31'd0, irq}, 32'd0);
      rd(A_PEND, d);  chk("R1 pend", d, 32'd0);
      rd(A_MASK, d);  chk("R1 mask", d, 32'd0);
      rd(A_TR, d);    chk("R1 trig_r", d, 32'd0);
      rd(A_TF, d);    chk("R1 trig_f", d, 32'd0);
      rd(A_IDENT, d); chk("R1 ident", d, 32'd0);

      // R12 upper bits ignored
      wr(A_MASK, 32'hFFFF_FFFF);
      rd(A_MASK, d);  chk("R12 upper mask bits", d, LOW);
      // R4 direct zero masks all
      wr(A_MASK, 32'd0);
      rd(A_MASK, d);  chk("R4 mask zero", d, 32'd0);

      // R3 aliases, zero bits no effect
      wr(A_MSET, 32'h0000_00F0);
      wr(A_MSET, 32'h0000_0003);
      rd(A_MSET, d);  chk("R3 set alias", d, 32'h0000_00F3);
      wr(A_MCLR, 32'h0000_0030);
      rd(A_MCLR, d);  chk("R3 clear alias", d, 32'h0000_00C3);
      wr(A_MASK, 32'd0);

      // R6 level detection and R2 partial clear
      src = 24'h00_0A05;
      settle();
      src = '0;
      settle();
      rd(A_PEND, d);  chk("R6 level latch", d, 32'h0000_0A05);
      wr(A_PEND, 32'h0000_0004);
      rd(A_PEND, d);  chk("R2 w1c one bit", d, 32'h0000_0A01);
      wr(A_PEND, 32'hFFFF_FFFF);
      rd(A_PEND, d);  chk("R2 clear all", d, 32'd0);

      // R10 set beats clear while level source held high
      src = 24'h00_0100;
      settle();
      wr(A_PEND, 32'h0000_0100);
      rd(A_PEND, d);  chk("R10 set wins", d, 32'h0000_0100);
      // R6 re-latch after clear while asserted
      wr(A_PEND, 32'hFFFF_FFFF);
      @(negedge clk);
      rd(A_PEND, d);  chk("R6 relatch", d, 32'h0000_0100);
      src = '0;
      settle();
      wr(A_PEND, 32'hFFFF_FFFF);

      // R11 registered output, one cycle after mask enables pending bit
      src = 24'h00_0200;
      settle();
      src = '0;
      settle();
      chk("R11 irq masked", {31'd0, irq}, 32'd0);
      wr(A_MSET, 32'h0000_0200);
      chk("R11 irq not yet", {31'd0, irq}, 32'd0);
      @(negedge clk);
      chk("R11 irq high", {31'd0, irq}, 32'd1);
      rd(A_IDENT, d); chk("R5 ident", d, 32'h0000_0200);
      wr(A_MASK, 32'd0);
      wr(A_PEND, 32'hFFFF_FFFF);

      // R7 rising edge only on source 0
      wr(A_TR, 32'h0000_0001);
      src[0] = 1'b1;
      settle();
      rd(A_PEND, d);  chk("R7 rise latch", d, 32'h0000_0001);
      wr(A_PEND, 32'h0000_0001);
      settle();
      rd(A_PEND, d);  chk("R7 held high no relatch", d, 32'd0);
      src[0] = 1'b0;
      settle();
      rd(A_PEND, d);  chk("R7 fall ignored", d, 32'd0);

      // R8 falling edge only on source 1
      wr(A_TF, 32'h0000_0002);
      src[1] = 1'b1;
      settle();
      rd(A_PEND, d);  chk("R8 rise ignored", d, 32'd0);
      src[1] = 1'b0;
      settle();
      rd(A_PEND, d);  chk("R8 fall latch", d, 32'h0000_0002);
      wr(A_PEND, 32'hFFFF_FFFF);
      settle();
      rd(A_PEND, d);  chk("R8 low no relatch", d, 32'd0);

      // R9 both edges on source 2
      wr(A_TR, 32'h0000_0005);
      wr(A_TF, 32'h0000_0006);
      src[2] = 1'b1;
      settle();
      rd(A_PEND, d);  chk("R9 rise", d, 32'h0000_0004);
      wr(A_PEND, 32'h0000_0004);
      settle();
      rd(A_PEND, d);  chk("R9 hold", d, 32'd0);
      src[2] = 1'b0;
      settle();
      rd(A_PEND, d);  chk("R9 fall", d, 32'h0000_0004);
      wr(A_PEND, 32'hFFFF_FFFF);
      wr(A_TR, 32'd0);
      wr(A_TF, 32'd0);

      // Random: mask paths (R3 R4) with level patterns (R5 R6 R11)
      mdl_mask = '0;
      wr(A_MASK, 32'd0);
      for (int it = 0; it < 40; it++) begin
         int op;
         logic [31:0] rdat;
         logic [NS-1:0] pat;
         op   = int'($urandom_range(0, 2));
         rdat = $urandom();
         if (it == 7) rdat = 32'd0;
         case (op)
            0:       wr(A_MASK, rdat);
            1:       wr(A_MSET, rdat);
            default: wr(A_MCLR, rdat);
         endcase
         mdl_mask = apply_mask_op(op, mdl_mask, rdat);
         pat = NS'($urandom());
         src = pat;
         settle();
         wr(A_PEND, 32'hFFFF_FFFF);
         rd(A_PEND, d);  chk("R6 random level", d, 32'(pat));
         rd(A_MASK, d);  chk("R3 R4 random mask", d, mdl_mask);
         rd(A_IDENT, d); chk("R5 random ident", d, exp_ident(32'(pat), mdl_mask));
         chk("R11 random irq", {31'd0, irq}, {31'd0, |exp_ident(32'(pat), mdl_mask)});
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule